// File: doc/BRIEF.md
# Guarded Power-Mode Entry Controller

This block watches the special-function-register write bus of a small microcontroller. It decides when the core may stop for idle or for power-down. A mode is entered only after a two-instruction handshake on one control register. The first instruction sets the mode's arm bit and leaves its start bit clear. The instruction that completes next must set the start bit and leave the arm bit clear. Any other pattern discards the arm state. That includes an extra instruction in between, a start for the other mode, or arm and start written together.

A register write commits only in the cycle where the core's instruction-boundary strobe is high. Each completed instruction therefore counts exactly once when the block judges whether two instructions are consecutive. The idle and power-down outputs go to the clock and power logic. An enabled-interrupt input ends idle. Power-down is left only through hardware reset. The four command bits clear themselves and always read back as zero. The other bits of the register keep whatever was last written to them.

Top module: `pwr_entry_guard`

## Requirements
- R1: Idle is entered when a control write sets bit 0 with bit 5 clear, and the very next completed instruction is a control write that sets bit 5 with bit 0 clear. `idle_o` rises at the clock edge that commits the second write.
- R2: Power-down is entered in the same way. The arm write sets bit 1 with bit 6 clear, and the following instruction's control write sets bit 6 with bit 1 clear. `pdown_o` rises at the clock edge that commits the second write.
- R3: Bits 0, 1, 5 and 6 of `ctrl_rdata` always read 0. Every other bit returns the value of the most recent committed control write, and is 0 after reset.
- R4: A single write that sets both the arm bit and the start bit of one mode does not enter that mode. It also does not count as arming that mode.
- R5: The arm state is lost at the next completed instruction that is not the matching start write. This includes an instruction with no write and a write to another address.
- R6: An arm write for one mode followed by a start write for the other mode enters neither mode and clears the arm state.
- R7: When idle and power-down are both started by the same write, after both were armed by the previous instruction, power-down is entered and idle is not.
- R8: While idle, a high `wake_irq` returns the block to run mode, and `idle_o` is low after the next clock edge. `wake_irq` has no effect in run mode.
- R9: Power-down ignores `wake_irq` and holds until reset.
- R10: While idle or powered down, control writes are ignored, and `ctrl_rdata` keeps its value.
- R11: After reset, `idle_o` and `pdown_o` are 0 and `ctrl_rdata` is 0.
- R12: A control write presented while `instr_end` is low commits nothing. It neither changes `ctrl_rdata` nor arms a mode.
- R13: At most one of `idle_o` and `pdown_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe from the core |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | DATA_W | Write data |
| instr_end | input | 1 | High for one cycle when an instruction completes; the write commits in that cycle |
| wake_irq | input | 1 | An enabled interrupt is pending |
| idle_o | output | 1 | Core is in idle mode |
| pdown_o | output | 1 | Core is in power-down mode |
| ctrl_rdata | output | DATA_W | Read value of the power-control register |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, an 8-bit address, the control register at 0x87, and the command bits at 0, 5, 1 and 6. With that layout the bench can drive every mixed pattern directly. These include both arm bits in one write, both start bits in one write, arm and start of one mode together, and an arm of one mode with a start of the other. It can also place idle cycles without an instruction end between the two writes. That separates "next instruction" from "next clock", and it makes the priority, cross-mode and expiry cases reachable in a few dozen cycles.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_mode_e;

  // Arm-or-start request: the wanted bit set, its partner bit clear.
  function automatic logic f_solo(input logic [31:0] data, input int want, input int other);
    return data[want] & ~data[other];
  endfunction

  // Mask of the self-clearing command bits.
  function automatic logic [31:0] f_cmd_mask(input int a, input int b, input int c, input int d);
    logic [31:0] m;
    m = '0;
    m[a] = 1'b1;
    m[b] = 1'b1;
    m[c] = 1'b1;
    m[d] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pg_decode.sv
module pg_decode
  import pwr_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h87,
  parameter int IDLE_ARM_BIT = 0,
  parameter int IDLE_GO_BIT  = 5,
  parameter int PD_ARM_BIT   = 1,
  parameter int PD_GO_BIT    = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              instr_end,
  input  logic              run,
  output logic              commit,
  output logic              idle_arm,
  output logic              idle_go,
  output logic              pd_arm,
  output logic              pd_go
);
  logic [31:0] wide;

  always_comb begin
    wide = 32'(wr_data);
    commit   = wr_en & instr_end & run & (wr_addr == CTRL_ADDR);
    idle_arm = commit & f_solo(wide, IDLE_ARM_BIT, IDLE_GO_BIT);
    idle_go  = commit & f_solo(wide, IDLE_GO_BIT, IDLE_ARM_BIT);
    pd_arm   = commit & f_solo(wide, PD_ARM_BIT, PD_GO_BIT);
    pd_go    = commit & f_solo(wide, PD_GO_BIT, PD_ARM_BIT);
  end
endmodule

// File: rtl/pg_arm_track.sv
module pg_arm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_end,
  input  logic run,
  input  logic idle_arm,
  input  logic idle_go,
  input  logic pd_arm,
  input  logic pd_go,
  output logic req_idle,
  output logic req_pd
);
  logic armed_idle_q, armed_pd_q;

  // Arm state lives for exactly one following instruction boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_idle_q <= 1'b0;
      armed_pd_q   <= 1'b0;
    end else if (!run) begin
      armed_idle_q <= 1'b0;
      armed_pd_q   <= 1'b0;
    end else if (instr_end) begin
      armed_idle_q <= idle_arm;
      armed_pd_q   <= pd_arm;
    end
  end

  assign req_idle = idle_go & armed_idle_q;
  assign req_pd   = pd_go & armed_pd_q;

  // R5: a completed instruction that does not arm leaves nothing armed.
  a_r5_arm_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_end && !idle_arm && !pd_arm) |=> (!armed_idle_q && !armed_pd_q));
endmodule

// File: rtl/pg_ctrl_reg.sv
module pg_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_MASK = 'h63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rdata
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (CMD_MASK[i]) begin : g_cmd
      assign rdata[i] = 1'b0;
    end else begin : g_store
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= 1'b0;
        else if (commit) q <= wr_data[i];
      end
      assign rdata[i] = q;
    end
  end

  // R10: without a committed write the register holds.
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rdata));
endmodule

// File: rtl/pg_mode_fsm.sv
module pg_mode_fsm
  import pwr_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_idle,
  input  logic     req_pd,
  input  logic     wake_irq,
  output pm_mode_e mode,
  output logic     run
);
  pm_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_RUN: begin
        if (req_pd)        mode_d = PM_DOWN;
        else if (req_idle) mode_d = PM_IDLE;
      end
      PM_IDLE: if (wake_irq) mode_d = PM_RUN;
      PM_DOWN: mode_d = PM_DOWN;
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
  assign run  = (mode_q == PM_RUN);

  // R7: simultaneous requests resolve to power-down.
  a_r7_pd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (run && req_pd && req_idle) |=> (mode == PM_DOWN));
  // R9: power-down only leaves through reset.
  a_r9_pd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_DOWN) |=> (mode == PM_DOWN));
  // R8: wake during idle returns to run after one edge.
  a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_IDLE && wake_irq) |=> run);
endmodule

// File: rtl/pwr_entry_guard.sv
module pwr_entry_guard
  import pwr_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h87,
  parameter int IDLE_ARM_BIT = 0,
  parameter int IDLE_GO_BIT  = 5,
  parameter int PD_ARM_BIT   = 1,
  parameter int PD_GO_BIT    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              instr_end,
  input  logic              wake_irq,
  output logic              idle_o,
  output logic              pdown_o,
  output logic [DATA_W-1:0] ctrl_rdata
);
  localparam logic [31:0] MASK32 = f_cmd_mask(IDLE_ARM_BIT, IDLE_GO_BIT, PD_ARM_BIT, PD_GO_BIT);
  localparam logic [DATA_W-1:0] CMD_MASK = MASK32[DATA_W-1:0];

  logic     run, commit;
  logic     idle_arm, idle_go, pd_arm, pd_go;
  logic     req_idle, req_pd;
  pm_mode_e mode;

  pg_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .IDLE_ARM_BIT(IDLE_ARM_BIT), .IDLE_GO_BIT(IDLE_GO_BIT),
    .PD_ARM_BIT(PD_ARM_BIT), .PD_GO_BIT(PD_GO_BIT)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .instr_end(instr_end), .run(run), .commit(commit),
    .idle_arm(idle_arm), .idle_go(idle_go), .pd_arm(pd_arm), .pd_go(pd_go)
  );

  pg_arm_track u_arm (
    .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .run(run),
    .idle_arm(idle_arm), .idle_go(idle_go), .pd_arm(pd_arm), .pd_go(pd_go),
    .req_idle(req_idle), .req_pd(req_pd)
  );

  pg_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_pd(req_pd),
    .wake_irq(wake_irq), .mode(mode), .run(run)
  );

  pg_ctrl_reg #(.DATA_W(DATA_W), .CMD_MASK(CMD_MASK)) u_reg (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wr_data(wr_data), .rdata(ctrl_rdata)
  );

  assign idle_o  = (mode == PM_IDLE);
  assign pdown_o = (mode == PM_DOWN);

  // R13: never both modes at once.
  a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idle_o, pdown_o}));
  // R1: idle only begins at a committed start write.
  a_r1_idle_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(commit && wr_data[IDLE_GO_BIT]));
  // R4: arm and start of idle in one write never enters idle.
  a_r4_joint_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && instr_end && wr_addr == CTRL_ADDR &&
     wr_data[IDLE_ARM_BIT] && wr_data[IDLE_GO_BIT]) |=> !idle_o);
  // R3: command bits read zero.
  a_r3_cmd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata & CMD_MASK) == '0);
endmodule

// File: tb/tb_pwr_entry_guard.sv
module tb_pwr_entry_guard;
  localparam logic [7:0] CA = 8'h87;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       instr_end = 1'b0;
  logic       wake_irq = 1'b0;
  logic       idle_o, pdown_o;
  logic [7:0] ctrl_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int         m_mode = 0;   // 0 run, 1 idle, 2 power-down
  bit         m_ai = 0, m_ap = 0;
  logic [7:0] m_reg = '0;

  logic [9:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  pwr_entry_guard dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .instr_end(instr_end), .wake_irq(wake_irq),
    .idle_o(idle_o), .pdown_o(pdown_o), .ctrl_rdata(ctrl_rdata)
  );

  task automatic compare(input logic [9:0] exp, input string tag);
    logic [9:0] act;
    act = {idle_o, pdown_o, ctrl_rdata};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: idle/pd/rdata actual %b/%b/%h expected %b/%b/%h",
               tag, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
    end
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) compare(q_exp.pop_front(), q_tag.pop_front());
  end

  // driver: one cycle of stimulus, model advanced from the requirements
  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                      input bit ie, input bit irq, input string tag);
    bit hit, ia, ig, pa, pg;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; instr_end = ie; wake_irq = irq;
    if (m_mode == 0) begin
      if (ie) begin
        hit = we && (a == CA);
        ia = hit && d[0] && !d[5];
        ig = hit && d[5] && !d[0];
        pa = hit && d[1] && !d[6];
        pg = hit && d[6] && !d[1];
        if (pg && m_ap) m_mode = 2;
        else if (ig && m_ai) m_mode = 1;
        m_ai = ia;
        m_ap = pa;
        if (hit) m_reg = d & 8'h9C;
      end
    end else if (m_mode == 1 && irq) begin
      m_mode = 0;
    end
    if (m_mode != 0) begin m_ai = 0; m_ap = 0; end
    q_exp.push_back({m_mode == 1, m_mode == 2, m_reg});
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    step(1, CA, d, 1, 0, tag);
  endtask

  task automatic nop(input string tag);
    step(0, 8'h00, 8'h00, 1, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; instr_end = 0; wake_irq = 0;
    m_mode = 0; m_ai = 0; m_ap = 0; m_reg = '0;
    @(negedge clk);
    compare(10'b0, "R11 reset state");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 + R3: fresh register readback
    step(0, 8'h00, 8'h00, 0, 0, "R11 idle cycle");
    // R12: write without instruction end commits nothing
    step(1, CA, 8'h9D, 0, 0, "R12 uncommitted write");
    // R3: command bits self-clear, others store
    wr(8'hFF, "R3 write all ones");
    wr(8'h84, "R3 store other bits");
    // R8: wake in run has no effect
    step(0, 8'h00, 8'h00, 0, 1, "R8 wake in run");
    // R1: idle entry, with gap cycles that are not instructions
    wr(8'h01, "R1 arm idle");
    step(0, 8'h00, 8'h00, 0, 0, "R1 gap no instruction");
    wr(8'h20, "R1 start idle");
    // R10: writes ignored while idle
    wr(8'h9C, "R10 write in idle");
    step(0, 8'h00, 8'h00, 0, 0, "R10 idle holds");
    // R8: wake leaves idle
    step(0, 8'h00, 8'h00, 0, 1, "R8 wake exits idle");
    step(0, 8'h00, 8'h00, 0, 0, "R8 stays run");
    // R4: joint arm+start rejected, and not an arm either
    wr(8'h21, "R4 joint write");
    wr(8'h20, "R4 start after joint");
    // R5: intervening instruction discards arm
    wr(8'h01, "R5 arm idle");
    nop("R5 other instruction");
    wr(8'h20, "R5 late start");
    // R5: write to another address also counts as an instruction
    wr(8'h02, "R5 arm pd");
    step(1, 8'h55, 8'h40, 1, 0, "R5 other address");
    wr(8'h40, "R5 late pd start");
    // R12: arm without instruction end does not arm
    step(1, CA, 8'h01, 0, 0, "R12 arm without end");
    wr(8'h20, "R12 start after uncommitted arm");
    // R6: cross-mode start enters nothing and clears arm
    wr(8'h01, "R6 arm idle");
    wr(8'h40, "R6 start pd");
    wr(8'h20, "R6 start idle after cross");
    wr(8'h02, "R6 arm pd");
    wr(8'h20, "R6 start idle");
    // R2: power-down entry
    wr(8'h02, "R2 arm pd");
    wr(8'h40, "R2 start pd");
    // R9: wake ignored in power-down; R10 write ignored
    step(0, 8'h00, 8'h00, 0, 1, "R9 wake in pd");
    wr(8'h10, "R10 write in pd");
    step(0, 8'h00, 8'h00, 1, 1, "R9 still pd");
    do_reset();
    step(0, 8'h00, 8'h00, 0, 0, "R9 reset leaves pd");
    // R7: both armed, both started -> power-down
    wr(8'h03, "R7 arm both");
    wr(8'h60, "R7 start both");
    step(0, 8'h00, 8'h00, 0, 1, "R7 pd wins");
    do_reset();
    // R1 again after reset, via second entry path with data bits
    wr(8'h81, "R1 arm idle with data");
    wr(8'h24, "R1 start idle with data");
    step(0, 8'h00, 8'h00, 0, 1, "R8 wake");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule